// File: doc/BRIEF.md
# Dual-Plane Flash Status Controller

This block is the control and status front end of a small word-organised flash array. The array is split into two planes by the most significant address bit and into erase sectors by the top `SECT_BITS` address bits. A command port accepts program, sector erase, erase suspend, erase resume and sector lock requests. One operation engine times each program or erase with an internal cycle counter. The storage itself is a register file inside the block.

Reads are combinational from `rd_addr`. A read that falls in the region that is being programmed or erased returns a status word instead of array data. In that word, bit 7 is a data-polling bit and bit 6 is a toggle bit. A read of the idle plane returns array data. An active-low busy output covers every program and erase cycle. A separate flash reset input aborts the running operation and turns the data outputs off.

The engine has five states:
- ST_READY is the idle state. It moves to ST_PROG when a program is accepted and to ST_ERASE when an erase is accepted.
- ST_PROG returns to ST_READY when its count ends.
- ST_ERASE returns to ST_READY when its count ends. On a suspend it moves to ST_HELD.
- ST_HELD returns to ST_ERASE on a resume. It moves to ST_HELD_PROG when a program to another sector is accepted.
- ST_HELD_PROG returns to ST_HELD when its count ends.

Any state falls back to ST_READY while the flash reset input is low.

Top module: `flash_dual_plane`

## Requirements
- R1: After `rst_n` is released, the block is in read mode: `busy_n`=1, `cmd_err`=0, `dq_oe`=1, and every word reads 0xFF.
- R2: A program command (`cmd_op`=1) accepted in ST_READY holds `busy_n` low for exactly `PROG_CYC` cycles. After that the word reads old AND `cmd_data`, so a program can only clear bits.
- R3: While a program runs, a read of the programmed address returns bit 7 equal to the complement of bit 7 of the programmed data.
- R4: Each read in the busy region inverts bit 6 of the returned status word relative to the previous such read. Once the operation ends, repeated reads of the same address return the same array data.
- R5: The plane is address bit `ADDR_W`-1. During a program or an unsuspended erase, reads of the other plane return array data.
- R6: An erase command (`cmd_op`=2) sets every word of the sector given by the top `SECT_BITS` address bits to all ones after exactly `ERASE_CYC` busy cycles. It leaves all other sectors untouched. During the erase, a status read returns bit 7 = 0.
- R7: A suspend command (`cmd_op`=3) during an erase releases `busy_n` and holds the erase count. While the erase is held, other sectors of the same plane can be read and programmed. A resume command (`cmd_op`=4) continues the count, so the erase spends `ERASE_CYC` busy cycles in total.
- R8: A lock command (`cmd_op`=5) in ST_READY protects the addressed sector. Later program or erase requests to that sector are rejected, and its contents stay unchanged.
- R9: The following requests are ignored, and each raises `cmd_err` for exactly the one cycle after the command:
  - a program or erase while an operation runs;
  - a program to the held sector;
  - a program or erase to a locked sector;
  - a suspend outside ST_ERASE;
  - a resume outside ST_HELD.
- R10: While `flash_rst_n` is low, `dq_oe`=0 and `rd_data`=0, and commands are ignored. An operation that was running is aborted: `busy_n` is 1 one cycle later and the target word keeps its old value. When `flash_rst_n` goes high again, normal reads resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| flash_rst_n | input | 1 | Dedicated array reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code: 1 program, 2 erase, 3 suspend, 4 resume, 5 lock |
| cmd_addr | input | ADDR_W | Command word address (sector taken from the top bits) |
| cmd_data | input | DATA_W | Program data |
| rd_en | input | 1 | Read strobe (advances the toggle bit on status reads) |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Array data or status word |
| dq_oe | output | 1 | Data output enable, low means high impedance |
| busy_n | output | 1 | Low during program and erase cycles |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The assertions rely on the commands arriving at least two cycles apart. Only under that condition is `cmd_err` a single-cycle pulse. The protection properties assume the lock command is issued only in ST_READY, because that is the only state in which the block accepts it. The bench drives every command and read through tasks that take two clock cycles each, which keeps the strobes spaced. Its random programs draw only from sectors the reference model knows are unlocked.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4,
        OP_LOCK   = 3'd5
    } fpc_op_e;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PROG,
        ST_ERASE,
        ST_HELD,
        ST_HELD_PROG
    } fpc_state_e;

endpackage

// File: rtl/fpc_seq.sv
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frst_n,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [ADDR_W-1:0]           cmd_addr,
    input  logic [DATA_W-1:0]           cmd_data,
    input  logic [(1<<SECT_BITS)-1:0]   prot,
    output fpc_state_e                  state_q,
    output logic [ADDR_W-1:0]           p_addr,
    output logic [DATA_W-1:0]           p_data,
    output logic [SECT_BITS-1:0]        e_sect,
    output logic                        wr_prog,
    output logic                        wr_erase,
    output logic                        lock_set,
    output logic [SECT_BITS-1:0]        lock_sect,
    output logic                        busy_n,
    output logic                        err_q
);

    localparam int PC_W = $clog2(PROG_CYC + 1);
    localparam int EC_W = $clog2(ERASE_CYC + 1);

    fpc_state_e         state_d;
    logic [PC_W-1:0]    pcnt;
    logic [EC_W-1:0]    ecnt;
    logic [SECT_BITS-1:0] c_sect;
    fpc_op_e            op;
    logic               live;
    logic               want_prog, want_erase, want_susp, want_res, want_lock;
    logic               prog_ok, erase_ok, susp_ok, res_ok, lock_ok;
    logic               p_done, e_done;
    logic               take_prog, take_erase;

    assign c_sect     = cmd_addr[ADDR_W-1 -: SECT_BITS];
    assign op         = fpc_op_e'(cmd_op);
    assign live       = cmd_valid && frst_n;
    assign want_prog  = live && (op == OP_PROG);
    assign want_erase = live && (op == OP_ERASE);
    assign want_susp  = live && (op == OP_SUSP);
    assign want_res   = live && (op == OP_RESUME);
    assign want_lock  = live && (op == OP_LOCK);

    assign p_done = (pcnt == PC_W'(PROG_CYC - 1));
    assign e_done = (ecnt == EC_W'(ERASE_CYC - 1));

    // Acceptance rules per request
    assign prog_ok  = !prot[c_sect] &&
                      ((state_q == ST_READY) ||
                       ((state_q == ST_HELD) && (c_sect != e_sect)));
    assign erase_ok = (state_q == ST_READY) && !prot[c_sect];
    assign susp_ok  = (state_q == ST_ERASE) && !e_done;
    assign res_ok   = (state_q == ST_HELD);
    assign lock_ok  = (state_q == ST_READY);

    assign take_prog  = want_prog && prog_ok;
    assign take_erase = want_erase && erase_ok;
    assign lock_sect  = c_sect;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (take_prog)       state_d = ST_PROG;
                else if (take_erase) state_d = ST_ERASE;
            end
            ST_PROG: begin
                if (p_done)          state_d = ST_READY;
            end
            ST_ERASE: begin
                if (e_done)          state_d = ST_READY;
                else if (want_susp)  state_d = ST_HELD;
            end
            ST_HELD: begin
                if (want_res)        state_d = ST_ERASE;
                else if (take_prog)  state_d = ST_HELD_PROG;
            end
            ST_HELD_PROG: begin
                if (p_done)          state_d = ST_HELD;
            end
            default:                 state_d = ST_READY;
        endcase
        if (!frst_n) state_d = ST_READY;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Counters, operand latches and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt   <= '0;
            ecnt   <= '0;
            p_addr <= '0;
            p_data <= '0;
            e_sect <= '0;
            err_q  <= 1'b0;
        end else begin
            if (take_prog) begin
                pcnt   <= '0;
                p_addr <= cmd_addr;
                p_data <= cmd_data;
            end else if ((state_q == ST_PROG || state_q == ST_HELD_PROG) && !p_done) begin
                pcnt <= pcnt + 1'b1;
            end

            if (take_erase) begin
                ecnt   <= '0;
                e_sect <= c_sect;
            end else if (state_q == ST_ERASE && !e_done) begin
                ecnt <= ecnt + 1'b1;
            end

            err_q <= (want_prog  && !prog_ok)  ||
                     (want_erase && !erase_ok) ||
                     (want_susp  && !susp_ok)  ||
                     (want_res   && !res_ok)   ||
                     (want_lock  && !lock_ok);
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy_n   = 1'b1;
        wr_prog  = 1'b0;
        wr_erase = 1'b0;
        unique case (state_q)
            ST_PROG, ST_HELD_PROG: begin
                busy_n  = 1'b0;
                wr_prog = p_done && frst_n;
            end
            ST_ERASE: begin
                busy_n   = 1'b0;
                wr_erase = e_done && frst_n;
            end
            default: ;
        endcase
        lock_set = want_lock && lock_ok;
    end

endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_prog,
    input  logic [ADDR_W-1:0]           p_addr,
    input  logic [DATA_W-1:0]           p_data,
    input  logic                        wr_erase,
    input  logic [SECT_BITS-1:0]        e_sect,
    input  logic                        lock_set,
    input  logic [SECT_BITS-1:0]        lock_sect,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_word,
    output logic [(1<<SECT_BITS)-1:0]   prot
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NSECT = 1 << SECT_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [SECT_BITS-1:0] WSECT = SECT_BITS'(g >> (ADDR_W - SECT_BITS));
        localparam logic [ADDR_W-1:0]    WADDR = ADDR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                mem[g] <= '1;
            else if (wr_erase && e_sect == WSECT)      mem[g] <= '1;
            else if (wr_prog && p_addr == WADDR)       mem[g] <= mem[g] & p_data;
        end
    end

    for (genvar s = 0; s < NSECT; s++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                            prot[s] <= 1'b0;
            else if (lock_set && lock_sect == SECT_BITS'(s))      prot[s] <= 1'b1;
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/fpc_status.sv
module fpc_status
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frst_n,
    input  fpc_state_e              state_q,
    input  logic [ADDR_W-1:0]       p_addr,
    input  logic [DATA_W-1:0]       p_data,
    input  logic [SECT_BITS-1:0]    e_sect,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [DATA_W-1:0]       rd_word,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    dq_oe
);

    localparam int PLANE = ADDR_W - 1;

    logic tgl;
    logic prog_hit, er_hit;
    logic [SECT_BITS-1:0] rd_sect;

    assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_BITS];
    assign prog_hit = (state_q == ST_PROG || state_q == ST_HELD_PROG) &&
                      (rd_addr[PLANE] == p_addr[PLANE]);
    assign er_hit   = ((state_q == ST_ERASE) && (rd_addr[PLANE] == e_sect[SECT_BITS-1])) ||
                      ((state_q == ST_HELD || state_q == ST_HELD_PROG) && (rd_sect == e_sect));

    always_comb begin
        rd_data = '0;
        if (!frst_n) begin
            rd_data = '0;
        end else if (prog_hit) begin
            rd_data[7] = ~p_data[7];
            rd_data[6] = tgl;
        end else if (er_hit) begin
            rd_data[6] = tgl;
        end else begin
            rd_data = rd_word;
        end
    end

    assign dq_oe = frst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   tgl <= 1'b0;
        else if (rd_en && frst_n && (prog_hit || er_hit)) tgl <= ~tgl;
    end

endmodule

// File: rtl/flash_dual_plane.sv
module flash_dual_plane
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flash_rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                dq_oe,
    output logic                busy_n,
    output logic                cmd_err
);

    localparam int NSECT = 1 << SECT_BITS;

    fpc_state_e             state_q;
    logic [ADDR_W-1:0]      p_addr;
    logic [DATA_W-1:0]      p_data;
    logic [SECT_BITS-1:0]   e_sect;
    logic                   wr_prog, wr_erase, lock_set;
    logic [SECT_BITS-1:0]   lock_sect;
    logic [NSECT-1:0]       prot;
    logic [DATA_W-1:0]      rd_word;

    fpc_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .frst_n(flash_rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .prot(prot), .state_q(state_q), .p_addr(p_addr), .p_data(p_data), .e_sect(e_sect),
        .wr_prog(wr_prog), .wr_erase(wr_erase), .lock_set(lock_set), .lock_sect(lock_sect),
        .busy_n(busy_n), .err_q(cmd_err)
    );

    fpc_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .wr_prog(wr_prog), .p_addr(p_addr), .p_data(p_data),
        .wr_erase(wr_erase), .e_sect(e_sect), .lock_set(lock_set), .lock_sect(lock_sect),
        .rd_addr(rd_addr), .rd_word(rd_word), .prot(prot)
    );

    fpc_status #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .frst_n(flash_rst_n), .state_q(state_q),
        .p_addr(p_addr), .p_data(p_data), .e_sect(e_sect), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_word(rd_word), .rd_data(rd_data), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         flash_rst_n,
    input logic                         busy_n,
    input logic                         cmd_err,
    input fpc_state_e                   state_q,
    input logic                         wr_prog,
    input logic                         wr_erase,
    input logic [ADDR_W-1:0]            p_addr,
    input logic [DATA_W-1:0]            p_data,
    input logic [SECT_BITS-1:0]         e_sect,
    input logic [(1<<SECT_BITS)-1:0]    prot,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [DATA_W-1:0]            rd_data
);

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err); // R9

    AST_ABORT_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |=> busy_n); // R10

    AST_PROG_WRITE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prog |-> !prot[p_addr[ADDR_W-1 -: SECT_BITS]]); // R8

    AST_ERASE_WRITE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_erase |-> !prot[e_sect]); // R8

    AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prog || wr_erase) |-> !busy_n); // R2

    AST_POLL_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && flash_rst_n && rd_addr == p_addr) |-> (rd_data[7] == ~p_data[7])); // R3

endmodule

bind flash_dual_plane fpc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flash_rst_n(flash_rst_n), .busy_n(busy_n),
    .cmd_err(cmd_err), .state_q(state_q), .wr_prog(wr_prog), .wr_erase(wr_erase),
    .p_addr(p_addr), .p_data(p_data), .e_sect(e_sect), .prot(prot),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_flash_dual_plane.sv
module test_flash_dual_plane;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int PC = 8;
    localparam int EC = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flash_rst_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          dq_oe, busy_n, cmd_err;

    int checks = 0;
    int errors = 0;
    int busy_cyc = 0;
    logic [DW-1:0] mem_m [64];
    logic [3:0]    prot_m = '0;

    always #10 clk = ~clk;

    always @(negedge clk) if (rst_n && !busy_n) busy_cyc++;

    flash_dual_plane #(.ADDR_W(AW), .DATA_W(DW), .SECT_BITS(2),
                       .PROG_CYC(PC), .ERASE_CYC(EC)) i_flash_dual_plane (
        .clk(clk), .rst_n(rst_n), .flash_rst_n(flash_rst_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .dq_oe(dq_oe), .busy_n(busy_n),
        .cmd_err(cmd_err)
    );

    function automatic logic [DW-1:0] prog_result(logic [DW-1:0] old, logic [DW-1:0] d);
        return old & d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        e = cmd_err;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && !busy_n; k++) @(negedge clk);
    endtask

    task automatic sweep(input int lo, input int hi, input string req);
        logic [DW-1:0] v;
        for (int a = lo; a <= hi; a++) begin
            rd(AW'(a), v);
            chk(v == mem_m[a], req, v, mem_m[a]);
        end
    endtask

    initial begin
        logic [DW-1:0] v, v2;
        logic e;
        int b0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem_m[i] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
        chk(cmd_err == 1'b0, "R1 cmd_err", cmd_err, 0);
        chk(dq_oe == 1'b1, "R1 dq_oe", dq_oe, 1);
        sweep(0, 63, "R1 erased array");

        // R2 R3 R4 R5: program with polling, toggle and other-plane read
        mem_m[20] = prog_result(mem_m[20], 8'h0F);
        issue(3'd1, 6'd20, 8'h0F, e);
        wait_idle();
        mem_m[40] = prog_result(mem_m[40], 8'h11);
        issue(3'd1, 6'd40, 8'h11, e);
        wait_idle();
        b0 = busy_cyc;
        mem_m[5] = prog_result(mem_m[5], 8'hA5);
        issue(3'd1, 6'd5, 8'hA5, e);
        chk(busy_n == 1'b0, "R2 busy after accept", busy_n, 0);
        rd(6'd5, v);
        chk(v[7] == 1'b0, "R3 polling bit", v[7], 0);
        rd(6'd5, v2);
        chk(v[6] != v2[6], "R4 toggle differs", v2[6], ~v[6]);
        rd(6'd40, v);
        chk(v == mem_m[40], "R5 other plane during program", v, mem_m[40]);
        wait_idle();
        chk(busy_cyc - b0 == PC, "R2 program cycles", busy_cyc - b0, PC);
        rd(6'd5, v);
        rd(6'd5, v2);
        chk(v == 8'hA5 && v2 == v, "R4 stable after done", v2, 8'hA5);
        mem_m[5] = prog_result(mem_m[5], 8'h3C);
        issue(3'd1, 6'd5, 8'h3C, e);
        wait_idle();
        rd(6'd5, v);
        chk(v == 8'h24, "R2 program only clears", v, 8'h24);

        // R6: erase sector 0 with other-plane read and status bits
        b0 = busy_cyc;
        issue(3'd2, 6'd3, 8'h00, e);
        rd(6'd7, v);
        chk(v[7] == 1'b0, "R6 erase status bit7", v[7], 0);
        rd(6'd7, v2);
        chk(v[6] != v2[6], "R4 toggle during erase", v2[6], ~v[6]);
        rd(6'd40, v);
        chk(v == mem_m[40], "R5 other plane during erase", v, mem_m[40]);
        wait_idle();
        for (int i = 0; i < 16; i++) mem_m[i] = 8'hFF;
        chk(busy_cyc - b0 == EC, "R6 erase cycles", busy_cyc - b0, EC);
        sweep(0, 23, "R6 erase result");

        // R7 R9: suspend, access sibling sector, reject held sector, resume
        mem_m[3] = prog_result(mem_m[3], 8'h5A);
        issue(3'd1, 6'd3, 8'h5A, e);
        wait_idle();
        b0 = busy_cyc;
        issue(3'd2, 6'd18, 8'h00, e);
        repeat (4) @(negedge clk);
        issue(3'd3, 6'd18, 8'h00, e);
        chk(busy_n == 1'b1, "R7 suspend releases busy", busy_n, 1);
        rd(6'd3, v);
        chk(v == mem_m[3], "R7 read sibling sector", v, mem_m[3]);
        issue(3'd1, 6'd25, 8'h00, e);
        chk(e == 1'b1, "R9 program to held sector", e, 1);
        @(negedge clk);
        chk(cmd_err == 1'b0, "R9 error one cycle", cmd_err, 0);
        mem_m[3] = prog_result(mem_m[3], 8'h81);
        issue(3'd1, 6'd3, 8'h81, e);
        chk(e == 1'b0, "R7 program during hold accepted", e, 0);
        wait_idle();
        rd(6'd3, v);
        chk(v == mem_m[3], "R7 program during hold", v, mem_m[3]);
        issue(3'd4, 6'd18, 8'h00, e);
        wait_idle();
        for (int i = 16; i < 32; i++) mem_m[i] = 8'hFF;
        chk(busy_cyc - b0 == EC + PC, "R7 total busy cycles", busy_cyc - b0, EC + PC);
        sweep(0, 31, "R7 after resume");

        // R9: commands while busy and misplaced suspend/resume
        mem_m[44] = prog_result(mem_m[44], 8'h70);
        issue(3'd1, 6'd44, 8'h70, e);
        issue(3'd2, 6'd33, 8'h00, e);
        chk(e == 1'b1, "R9 erase while busy", e, 1);
        issue(3'd1, 6'd8, 8'h00, e);
        chk(e == 1'b1, "R9 program other plane while busy", e, 1);
        wait_idle();
        issue(3'd4, 6'd0, 8'h00, e);
        chk(e == 1'b1, "R9 resume when idle", e, 1);
        issue(3'd3, 6'd0, 8'h00, e);
        chk(e == 1'b1, "R9 suspend when idle", e, 1);
        chk(busy_n == 1'b1, "R9 no operation started", busy_n, 1);
        sweep(32, 47, "R9 contents unchanged");
        sweep(8, 8, "R9 rejected program ignored");

        // R8: lock sector 3
        mem_m[50] = prog_result(mem_m[50], 8'hC3);
        issue(3'd1, 6'd50, 8'hC3, e);
        wait_idle();
        issue(3'd5, 6'd48, 8'h00, e);
        chk(e == 1'b0, "R8 lock accepted", e, 0);
        prot_m[3] = 1'b1;
        issue(3'd1, 6'd50, 8'h00, e);
        chk(e == 1'b1 && busy_n == 1'b1, "R8 program locked rejected", e, 1);
        issue(3'd2, 6'd50, 8'h00, e);
        chk(e == 1'b1 && busy_n == 1'b1, "R8 erase locked rejected", e, 1);
        sweep(48, 63, "R8 locked contents");

        // R10: flash reset aborts a program
        issue(3'd1, 6'd33, 8'h00, e);
        @(negedge clk);
        flash_rst_n = 1'b0;
        #1;
        chk(dq_oe == 1'b0, "R10 outputs off", dq_oe, 0);
        chk(rd_data == '0, "R10 data zero", rd_data, 0);
        @(negedge clk);
        chk(busy_n == 1'b1, "R10 abort releases busy", busy_n, 1);
        issue(3'd1, 6'd34, 8'h00, e);
        chk(e == 1'b0 && busy_n == 1'b1, "R10 command ignored", busy_n, 1);
        @(negedge clk);
        flash_rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 1'b1, "R10 outputs back", dq_oe, 1);
        sweep(33, 34, "R10 words unchanged");

        // R2 R5: constrained random programs outside locked sectors
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom % 64);
            d = DW'($urandom);
            if (prot_m[a[5:4]]) continue;
            mem_m[a] = prog_result(mem_m[a], d);
            b0 = busy_cyc;
            issue(3'd1, a, d, e);
            if ($urandom % 2 == 1) begin
                rd(a ^ 6'h20, v);
                chk(v == mem_m[a ^ 6'h20], "R5 random other plane", v, mem_m[a ^ 6'h20]);
            end
            wait_idle();
            chk(busy_cyc - b0 == PC, "R2 random program cycles", busy_cyc - b0, PC);
            rd(a, v);
            chk(v == mem_m[a], "R2 random program data", v, mem_m[a]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule